// File: doc/BRIEF.md
# Bus Access Timeout Acknowledger

This block sits beside a processor register bus that runs in the processor clock domain. The processor raises a request strobe and holds it, together with a byte address, until some target answers with an acknowledge. The block times each request. If no internal target acknowledges it within a programmed number of processor clock periods, the block can answer the request itself. The processor then completes the access instead of waiting forever.

The self-generated acknowledge can be switched off. In that case a timed-out access gets no answer at all, but the block still reports it. Every timeout raises a one-cycle event pulse and stores the word address of the failed access in a holding register. Diagnostic software can read that register later. Registers are 16 bits wide, so the word address is the byte address with its lowest bit removed.

The block does no address decoding, no read-data steering and has no register file. It merges the internal acknowledge with its own, and it keeps the last failed address.

Top module: `bus_timeout_ack`

## Requirements
- R1: After reset the captured word address is zero and no request is being timed. While the request strobe is low and no internal acknowledge arrives, neither the acknowledge output nor the timeout event is high.
- R2: The timeout limit is a 9-bit value N in the range 0 to 511, counted in clock periods. A request first sampled high at a rising edge and then held, with no internal acknowledge, raises the timeout event in the cycle that follows the (N+1)-th rising edge at which the strobe is sampled high. With N = 0 this is the cycle right after the request is seen.
- R3: The timeout event lasts exactly one cycle and occurs at most once per request, however long the strobe then stays high.
- R4: When the timeout-acknowledge enable is 1, the acknowledge output is high in the cycle of the timeout event. When the enable is 0, a timed-out request never gets an acknowledge.
- R5: An internal acknowledge appears on the acknowledge output in the same cycle. It ends the timing of the pending request, so that request never times out.
- R6: Dropping the strobe before the limit is reached discards the elapsed count. The next request is timed over the full window, and no timeout event occurs while the strobe is low.
- R7: On each timeout event, the captured word address takes the value of bus address bits [ADDR_W-1:1] of the timed-out request. It is updated at the rising edge that ends the event cycle, whether or not the acknowledge is enabled. At all other times it holds its value.
- R8: An internal acknowledge in the same cycle that would otherwise be the timeout cycle takes precedence. No timeout event is raised and the address is not captured.
- R9: Once a request has been answered, by a target or by a timeout, the strobe must go low for at least one cycle before a new request is timed. A strobe held high after an answer never raises a timeout event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, held high until the access is answered |
| bus_addr | input | ADDR_W | Byte address of the request, stable while the strobe is high |
| tgt_ack | input | 1 | Acknowledge from an internal target |
| tmo_limit | input | CNT_W | Timeout limit in clock periods (0 to 511) |
| tmo_ack_en | input | 1 | 1: answer timed-out requests; 0: leave them unanswered |
| bus_ack | output | 1 | Merged acknowledge to the processor |
| tmo_event | output | 1 | One-cycle pulse on each timeout |
| last_tmo_waddr | output | ADDR_W-1 | Word address of the most recent timed-out request |

## Verification
The hardest case to reach is an internal acknowledge that arrives in the very cycle the timeout would fire. It sits on a single cycle whose position depends on the programmed limit. The stimulus places the acknowledge at the exact cycle index, computed from the limit as limit+1 after the request is first driven, and also one cycle earlier and later. A second case is a strobe held high long after an answer, including with the largest limit of 511. This shows that no second event and no stray capture occur.

// File: rtl/bto_pkg.sv
package bto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } bto_state_e;

endpackage

// File: rtl/bto_timer.sv
module bto_timer
    import bto_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             tgt_ack,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    typedef struct packed {
        bto_state_e       st;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        case (tmr_q.st)
            ST_IDLE: begin
                if (req) begin
                    tmr_d.cnt = '0;
                    tmr_d.st  = tgt_ack ? ST_DONE : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!req) begin
                    tmr_d.st  = ST_IDLE;
                    tmr_d.cnt = '0;
                end else if (tgt_ack) begin
                    tmr_d.st  = ST_DONE;
                    tmr_d.cnt = '0;
                end else if (tmr_q.cnt >= limit) begin
                    expire    = 1'b1;
                    tmr_d.st  = ST_DONE;
                    tmr_d.cnt = '0;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end
            ST_DONE: begin
                if (!req) begin
                    tmr_d.st = ST_IDLE;
                end
            end
            default: begin
                tmr_d.st  = ST_IDLE;
                tmr_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.st  <= ST_IDLE;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);                                        // R3
    AST_TARGET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> !tgt_ack);                                       // R8
    AST_NO_REQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !expire);                                          // R6
    AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.st == ST_WAIT) |-> $past(req));                      // R6

endmodule

// File: rtl/bto_capture.sv
module bto_capture #(
    parameter int WA_W = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grab,
    input  logic [WA_W-1:0] waddr,
    output logic [WA_W-1:0] held
);

    typedef struct packed {
        logic [WA_W-1:0] wa;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (grab) begin
            cap_d.wa = waddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q.wa <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign held = cap_q.wa;

endmodule

// File: rtl/bus_timeout_ack.sv
module bus_timeout_ack #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              tgt_ack,
    input  logic [CNT_W-1:0]  tmo_limit,
    input  logic              tmo_ack_en,
    output logic              bus_ack,
    output logic              tmo_event,
    output logic [ADDR_W-2:0] last_tmo_waddr
);

    localparam int WA_W = ADDR_W - 1;

    logic            expire;
    logic [WA_W-1:0] word_addr;
    logic            unused_byte_lsb;

    assign word_addr       = bus_addr[ADDR_W-1:1];
    assign unused_byte_lsb = bus_addr[0];

    bto_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .tgt_ack (tgt_ack),
        .limit   (tmo_limit),
        .expire  (expire)
    );

    bto_capture #(
        .WA_W (WA_W)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .grab  (expire),
        .waddr (word_addr),
        .held  (last_tmo_waddr)
    );

    assign tmo_event = expire;
    assign bus_ack   = tgt_ack | (expire & tmo_ack_en);

    AST_ACK_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_event && tmo_ack_en) |-> bus_ack);                     // R4
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_event && !tmo_ack_en) |-> !bus_ack);                   // R4
    AST_TARGET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_ack |-> bus_ack);                                       // R5
    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_event |=> $stable(last_tmo_waddr));                    // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !tgt_ack) |-> (!bus_ack && !tmo_event));       // R1

endmodule

// File: tb/bus_timeout_ack_bench.sv
`timescale 1ns/1ps
module bus_timeout_ack_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        tgt_ack = 1'b0;
    logic [8:0]  tmo_limit = '0;
    logic        tmo_ack_en = 1'b0;
    logic        bus_ack;
    logic        tmo_event;
    logic [14:0] last_tmo_waddr;

    int total = 0;
    int bad = 0;
    int n_pulse = 0;
    int n_ack = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int          m_phase = 0;   // 0 free, 1 being timed, 2 answered
    int          m_seen = 0;    // rising edges with strobe high since timing began
    logic [14:0] m_last = '0;

    always #10 clk = ~clk;

    bus_timeout_ack u_bus_timeout_ack (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_req        (bus_req),
        .bus_addr       (bus_addr),
        .tgt_ack        (tgt_ack),
        .tmo_limit      (tmo_limit),
        .tmo_ack_en     (tmo_ack_en),
        .bus_ack        (bus_ack),
        .tmo_event      (tmo_event),
        .last_tmo_waddr (last_tmo_waddr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic r, input logic t);
        logic e_evt;
        logic e_ack;
        @(negedge clk);
        bus_req = r;
        tgt_ack = t;
        #5;
        e_evt = (m_phase == 1) && r && !t && (m_seen > int'(tmo_limit));
        e_ack = t || (e_evt && tmo_ack_en);
        chk(tmo_event == e_evt, "R2 event", int'(tmo_event), int'(e_evt));
        chk(bus_ack == e_ack, "R4/R5 ack", int'(bus_ack), int'(e_ack));
        chk(last_tmo_waddr == m_last, "R7 last address", int'(last_tmo_waddr), int'(m_last));
        if (tmo_event) n_pulse++;
        if (bus_ack) n_ack++;
        @(posedge clk);
        if (m_phase == 0) begin
            if (r) begin
                m_phase = t ? 2 : 1;
                m_seen  = 1;
            end
        end else if (m_phase == 1) begin
            if (!r) m_phase = 0;
            else if (t) m_phase = 2;
            else if (e_evt) begin
                m_phase = 2;
                m_last  = bus_addr[15:1];
            end else m_seen++;
        end else begin
            if (!r) m_phase = 0;
        end
    endtask

    // hold the strobe for 'hold' cycles; target answers in cycle 'ack_at' (-1: never)
    task automatic run_req(input logic [15:0] a, input int lim, input bit en,
                           input int hold, input int ack_at, input string tag);
        int exp_p;
        int exp_a;
        @(negedge clk);
        bus_addr   = a;
        tmo_limit  = lim[8:0];
        tmo_ack_en = en;
        n_pulse = 0;
        n_ack   = 0;
        for (int i = 0; i < hold; i++) cyc(1'b1, i == ack_at);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        exp_p = ((hold >= lim + 2) && (ack_at < 0 || ack_at > lim + 1)) ? 1 : 0;
        exp_a = exp_p * int'(en) + ((ack_at >= 0 && ack_at < hold) ? 1 : 0);
        chk(n_pulse == exp_p, {tag, " R3 event count"}, n_pulse, exp_p);
        chk(n_ack == exp_a, {tag, " R4 ack count"}, n_ack, exp_a);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc(1'b0, 1'b0);
        chk(last_tmo_waddr == 15'd0, "R1 reset address", int'(last_tmo_waddr), 0);
        chk(!bus_ack && !tmo_event, "R1 quiet outputs", int'(bus_ack), 0);

        // R2: limit 0 and limit 5, enable on
        run_req(16'h1235, 0, 1'b1, 3, -1, "R2 lim0");
        chk(last_tmo_waddr == 15'h091A, "R7 odd byte address", int'(last_tmo_waddr), 'h091A);
        run_req(16'h4000, 5, 1'b1, 7, -1, "R2 lim5 edge");
        run_req(16'h4002, 5, 1'b1, 6, -1, "R2 lim5 short");
        chk(last_tmo_waddr == 15'h2000, "R7 held after no timeout", int'(last_tmo_waddr), 'h2000);

        // R4: enable off, strobe held well past limit (also R3, R9)
        run_req(16'hBEEF, 3, 1'b0, 12, -1, "R4 off");
        chk(last_tmo_waddr == 15'h5F77, "R7 capture with ack off", int'(last_tmo_waddr), 'h5F77);

        // R5: target answers early
        run_req(16'h0010, 4, 1'b1, 10, 2, "R5 early");
        // R8: target answers on the timeout cycle, one before, one after
        run_req(16'h0020, 2, 1'b1, 8, 3, "R8 same");
        run_req(16'h0022, 2, 1'b1, 8, 2, "R8 before");
        run_req(16'h0024, 2, 1'b1, 8, 4, "R8 after");
        chk(last_tmo_waddr == 15'h0012, "R8 capture on real timeout", int'(last_tmo_waddr), 'h12);

        // R6: withdraw then re-request, full window again
        run_req(16'h0100, 4, 1'b1, 4, -1, "R6 withdrawn");
        run_req(16'h0102, 4, 1'b1, 6, -1, "R6 full window");

        // R9: strobe kept high after answer at largest limit
        run_req(16'hFFFE, 511, 1'b1, 530, -1, "R9 lim511");
        chk(last_tmo_waddr == 15'h7FFF, "R9 capture at max limit", int'(last_tmo_waddr), 'h7FFF);
        run_req(16'h0200, 1, 1'b1, 20, 0, "R9 ack then hold");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule